// File: doc/BRIEF.md
# GPIO Controller with Grouped Interrupts

This block is a register-mapped general purpose I/O unit for up to 32 lines. Each line has an output latch, a direction bit, a blink enable and an input polarity bit, all written and read over a simple single-cycle register bus (address, write strobe, write data, read data). Line inputs are synchronized and polarity-corrected. The corrected value is readable as the data-in word and also serves as the interrupt source.

Two interrupt paths exist per line. The level path uses the corrected input directly, gated by a level mask. The edge path latches a 0-to-1 transition of the corrected input into a cause word, which software acknowledges by writing zeros. The edge path is gated by its own mask. Because polarity inversion happens before edge detection, setting a line's polarity bit makes the edge path catch falling edges on the pad. Pending sources are ORed per group of eight lines into one summary interrupt output per group. The two mask registers sit at a parameterized base shift so that the unit fits different address layouts.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the direction word reads all ones (every line an input, pad_oe low). The output, blink, polarity, edge cause, edge mask and level mask words read zero.
- R2: A direction bit of 0 drives pad_oe high for that line and presents the output latch bit on pad_out. A direction bit of 1 keeps pad_oe low.
- R3: The data-in word (byte address 0x10) reads the pad value XOR the polarity word (0x0C). A pad change shows up after the second rising clock edge.
- R4: The level source of a line is its data-in bit ANDed with its level-mask bit (0x1C + MASK_BASE). It is not latched, so the summary output falls again when the input falls.
- R5: A 0-to-1 transition of a data-in bit sets the matching edge-cause bit (0x14) at the third rising edge after the pad change. With polarity 1 only pad falling edges set it. A cause bit raises an interrupt only while its edge-mask bit (0x18 + MASK_BASE) is 1.
- R6: Writing the edge-cause word clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R7: If an edge for a bit is detected in the same cycle as an acknowledge that writes 0 to that bit, the bit stays set.
- R8: Summary output irq_group[g] is the OR of the pending sources (level or edge) of lines 8g to 8g+7.
- R9: While a line's blink bit (0x08) is 1, its pad_out follows a square wave that toggles once every BLINK_DIV clocks, instead of the output latch (0x00).
- R10: The two mask words respond only at their offsets plus MASK_BASE. With a nonzero MASK_BASE, a write to the unshifted offset changes nothing.
- R11: The data-in word is read-only. Writes to it do not change what it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_LINES | Raw line inputs, asynchronous |
| pad_out | output | NUM_LINES | Line output values |
| pad_oe | output | NUM_LINES | Line output enables |
| irq_group | output | NUM_LINES/8 rounded up | Per-group summary interrupts |

## Verification
The functions that can fall in the same cycle are the edge detector setting a cause bit and a software acknowledge clearing it. The bench raises a line, counts the two synchronizer edges, and times the write-zero acknowledge so that it lands on the same clock edge that latches the new transition. The acknowledge also covers a second, older cause bit. A correct unit ends with the new bit still set and the older bit cleared, which shows that the acknowledge took effect while the edge still took priority.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef logic [31:0] word_t;

  localparam logic [7:0] OFF_OUT   = 8'h00;
  localparam logic [7:0] OFF_DIR   = 8'h04;
  localparam logic [7:0] OFF_BLINK = 8'h08;
  localparam logic [7:0] OFF_POL   = 8'h0C;
  localparam logic [7:0] OFF_DIN   = 8'h10;
  localparam logic [7:0] OFF_CAUSE = 8'h14;
  localparam logic [7:0] OFF_EMASK = 8'h18;
  localparam logic [7:0] OFF_LMASK = 8'h1C;

  // Next edge-cause word: acknowledge clears zeros written, new edges win.
  function automatic word_t cause_next(word_t cur, logic ack, word_t wd, word_t rise);
    word_t kept;
    kept = ack ? (cur & wd) : cur;
    return kept | rise;
  endfunction

  // Per-line pending source: unlatched level OR latched edge, each masked.
  function automatic word_t pending_of(word_t din, word_t lmask, word_t cause, word_t emask);
    return (din & lmask) | (cause & emask);
  endfunction
endpackage

// File: rtl/gpio_in_path.sv
module gpio_in_path
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pad_in,
  input  logic [NUM_LINES-1:0] pol,
  input  logic                 ack_en,
  input  logic [NUM_LINES-1:0] ack_data,
  output logic [NUM_LINES-1:0] data_in,
  output logic [NUM_LINES-1:0] rise_evt,
  output logic [NUM_LINES-1:0] cause_q
);
  logic [NUM_LINES-1:0] sync1, sync2, prev;
  word_t cause_w;

  assign data_in  = sync2 ^ pol;
  assign rise_evt = data_in & ~prev;
  assign cause_w  = cause_next(word_t'(cause_q), ack_en, word_t'(ack_data), word_t'(rise_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      cause_q <= '0;
    end else begin
      sync1   <= pad_in;
      sync2   <= sync1;
      prev    <= data_in;
      cause_q <= cause_w[NUM_LINES-1:0];
    end
  end

  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt != '0) |=> ((cause_q & $past(rise_evt)) == $past(rise_evt))); // R7

  AST_CAUSE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(rise_evt)) == '0)); // R5

  AST_ACK_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && rise_evt == '0) |=> (cause_q == ($past(cause_q) & $past(ack_data)))); // R6
endmodule

// File: rtl/gpio_out_path.sv
module gpio_out_path #(
  parameter int NUM_LINES = 32,
  parameter int BLINK_DIV = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] out_q,
  input  logic [NUM_LINES-1:0] dir_q,
  input  logic [NUM_LINES-1:0] blink_q,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic                 blink_phase
);
  localparam int CW = (BLINK_DIV > 2) ? $clog2(BLINK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(BLINK_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      blink_phase <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) blink_phase <= ~blink_phase;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign pad_out[i] = blink_q[i] ? blink_phase : out_q[i];
    assign pad_oe[i]  = ~dir_q[i];
  end

  AST_BLINK_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blink_phase) |-> ($past(cnt) == CNT_LAST)); // R9
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int GROUP     = 8,
  localparam int NG       = (NUM_LINES + GROUP - 1) / GROUP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] data_in,
  input  logic [NUM_LINES-1:0] lmask,
  input  logic [NUM_LINES-1:0] cause,
  input  logic [NUM_LINES-1:0] emask,
  output logic [NG-1:0]        irq_group
);
  word_t pend_w;
  logic [NG*GROUP-1:0] pend_pad;

  assign pend_w   = pending_of(word_t'(data_in), word_t'(lmask), word_t'(cause), word_t'(emask));
  assign pend_pad = (NG*GROUP)'(pend_w[NUM_LINES-1:0]);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign irq_group[g] = |pend_pad[g*GROUP +: GROUP];
  end

  AST_LEVEL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_in & lmask) != '0) |-> (irq_group != '0)); // R4

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_group != '0) |-> (((data_in & lmask) | (cause & emask)) != '0)); // R8
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8,
  parameter int MASK_BASE = 0,
  parameter int BLINK_DIV = 8,
  localparam int NG       = (NUM_LINES + 7) / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NG-1:0]        irq_group
);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFF_OUT);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(OFF_BLINK);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFF_POL);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFF_DIN);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
  localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(MASK_BASE + int'(OFF_EMASK));
  localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(MASK_BASE + int'(OFF_LMASK));

  logic [NUM_LINES-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
  logic [NUM_LINES-1:0] data_in, rise_evt, cause_q, wd;
  logic hit_out, hit_dir, hit_blink, hit_pol, hit_cause, hit_emask, hit_lmask;
  logic blink_phase;

  assign wd        = bus_wdata[NUM_LINES-1:0];
  assign hit_out   = bus_wr && (bus_addr == A_OUT);
  assign hit_dir   = bus_wr && (bus_addr == A_DIR);
  assign hit_blink = bus_wr && (bus_addr == A_BLINK);
  assign hit_pol   = bus_wr && (bus_addr == A_POL);
  assign hit_cause = bus_wr && (bus_addr == A_CAUSE);
  assign hit_emask = bus_wr && (bus_addr == A_EMASK);
  assign hit_lmask = bus_wr && (bus_addr == A_LMASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      if (hit_out)   out_q   <= wd;
      if (hit_dir)   dir_q   <= wd;
      if (hit_blink) blink_q <= wd;
      if (hit_pol)   pol_q   <= wd;
      if (hit_emask) emask_q <= wd;
      if (hit_lmask) lmask_q <= wd;
    end
  end

  gpio_in_path #(.NUM_LINES(NUM_LINES)) u_in (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pol(pol_q),
    .ack_en(hit_cause), .ack_data(wd),
    .data_in(data_in), .rise_evt(rise_evt), .cause_q(cause_q)
  );

  gpio_out_path #(.NUM_LINES(NUM_LINES), .BLINK_DIV(BLINK_DIV)) u_out (
    .clk(clk), .rst_n(rst_n), .out_q(out_q), .dir_q(dir_q), .blink_q(blink_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .blink_phase(blink_phase)
  );

  gpio_irq_summary #(.NUM_LINES(NUM_LINES), .GROUP(8)) u_sum (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .lmask(lmask_q),
    .cause(cause_q), .emask(emask_q), .irq_group(irq_group)
  );

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == A_OUT)   bus_rdata[NUM_LINES-1:0] = out_q;
    else if (bus_addr == A_DIR)   bus_rdata[NUM_LINES-1:0] = dir_q;
    else if (bus_addr == A_BLINK) bus_rdata[NUM_LINES-1:0] = blink_q;
    else if (bus_addr == A_POL)   bus_rdata[NUM_LINES-1:0] = pol_q;
    else if (bus_addr == A_DIN)   bus_rdata[NUM_LINES-1:0] = data_in;
    else if (bus_addr == A_CAUSE) bus_rdata[NUM_LINES-1:0] = cause_q;
    else if (bus_addr == A_EMASK) bus_rdata[NUM_LINES-1:0] = emask_q;
    else if (bus_addr == A_LMASK) bus_rdata[NUM_LINES-1:0] = lmask_q;
  end

  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dir |=> (pad_oe == ~$past(wd))); // R2

  AST_DIN_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIN) |=> $stable(pol_q)); // R11
endmodule

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
  localparam int N  = 32;
  localparam int DV = 4;
  localparam logic [7:0] A_OUT = 8'h00, A_DIR = 8'h04, A_BLINK = 8'h08, A_POL = 8'h0C,
                         A_DIN = 8'h10, A_CAUSE = 8'h14, A_EMASK = 8'h38, A_LMASK = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic [3:0] irq_group;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_unit #(.NUM_LINES(N), .ADDR_W(8), .MASK_BASE('h20), .BLINK_DIV(DV)) i_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_group(irq_group)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic settle_clear();
    pad_in = '0;
    tick(3);
    wr(A_CAUSE, 32'h0);
  endtask

  task automatic t_reset();
    rdchk("R1 dir", A_DIR, 32'hFFFF_FFFF);
    rdchk("R1 out", A_OUT, 0);
    rdchk("R1 blink", A_BLINK, 0);
    rdchk("R1 pol", A_POL, 0);
    rdchk("R1 cause", A_CAUSE, 0);
    rdchk("R1 emask", A_EMASK, 0);
    rdchk("R1 lmask", A_LMASK, 0);
    check("R1 oe", pad_oe, 0);
  endtask

  task automatic t_direction();
    wr(A_OUT, 32'h0000_00A5);
    check("R2 oe while input", pad_oe, 0);
    wr(A_DIR, 32'hFFFF_FF00);
    check("R2 oe when output", pad_oe, 32'h0000_00FF);
    check("R2 pad_out", {24'h0, pad_out[7:0]}, 32'hA5);
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(A_OUT, 32'h0);
  endtask

  task automatic t_polarity();
    pad_in = 32'h0000_0F00;
    tick(1);
    rdchk("R3 one edge still old", A_DIN, 0);
    tick(1);
    rdchk("R3 data-in", A_DIN, 32'h0000_0F00);
    wr(A_POL, 32'h0000_FF00);
    rdchk("R3 inverted", A_DIN, 32'h0000_F000);
    wr(A_DIN, 32'hFFFF_FFFF);
    rdchk("R11 read-only", A_DIN, 32'h0000_F000);
    wr(A_POL, 32'h0);
    settle_clear();
  endtask

  task automatic t_level();
    wr(A_LMASK, 32'h4);
    pad_in = 32'h4;
    tick(2);
    check("R4 level irq", irq_group, 4'b0001);
    pad_in = 32'h0;
    tick(2);
    check("R4 unlatched drop / R5 edge unmasked", irq_group, 4'b0000);
    wr(A_LMASK, 32'h0);
    settle_clear();
  endtask

  task automatic t_mask_base();
    wr(8'h1C, 32'h4);
    pad_in = 32'h4;
    tick(2);
    check("R10 unshifted offset ignored", irq_group, 0);
    rdchk("R10 lmask unchanged", A_LMASK, 0);
    settle_clear();
  endtask

  task automatic t_edge();
    wr(A_EMASK, 32'h8);
    pad_in = 32'h8;
    tick(2);
    rdchk("R5 not yet latched", A_CAUSE, 0);
    tick(1);
    rdchk("R5 latched", A_CAUSE, 32'h8);
    check("R5 edge irq", irq_group, 4'b0001);
    pad_in = 32'h0;
    tick(3);
    rdchk("R5 held after fall", A_CAUSE, 32'h8);
    wr(A_CAUSE, 32'hFFFF_FFFF);
    rdchk("R6 write one keeps", A_CAUSE, 32'h8);
    wr(A_CAUSE, 32'hFFFF_FFF7);
    rdchk("R6 write zero clears", A_CAUSE, 0);
    check("R6 irq gone", irq_group, 0);
    wr(A_EMASK, 32'h0);
  endtask

  task automatic t_falling();
    wr(A_POL, 32'h10);
    tick(2);
    wr(A_CAUSE, 32'h0);
    pad_in = 32'h10;
    tick(3);
    rdchk("R5 rising ignored with pol 1", A_CAUSE, 0);
    pad_in = 32'h0;
    tick(3);
    rdchk("R5 falling caught with pol 1", A_CAUSE, 32'h10);
    wr(A_POL, 32'h0);
    settle_clear();
  endtask

  task automatic t_collision();
    pad_in = 32'h3;
    tick(3);
    rdchk("R7 setup", A_CAUSE, 32'h3);
    pad_in = 32'h0;
    tick(3);
    pad_in = 32'h1;
    tick(2);
    wr(A_CAUSE, 32'h0);
    rdchk("R7 edge beats ack", A_CAUSE, 32'h1);
    settle_clear();
  endtask

  task automatic t_group();
    wr(A_LMASK, 32'h8000_0200);
    pad_in = 32'h0000_0200;
    tick(2);
    check("R8 group one", irq_group, 4'b0010);
    pad_in = 32'h8000_0200;
    tick(2);
    check("R8 groups one and three", irq_group, 4'b1010);
    wr(A_LMASK, 32'h0);
    settle_clear();
  endtask

  task automatic t_blink();
    logic prevv;
    int changes;
    wr(A_DIR, 32'hFFFF_FFDF);
    wr(A_OUT, 32'h20);
    wr(A_BLINK, 32'h20);
    changes = 0;
    prevv = pad_out[5];
    for (int k = 0; k < 4*DV; k++) begin
      tick(1);
      if (pad_out[5] !== prevv) changes++;
      prevv = pad_out[5];
    end
    check("R9 toggles per period", changes, 4);
    wr(A_BLINK, 32'h0);
    check("R9 latch restored", {31'h0, pad_out[5]}, 1);
    wr(A_DIR, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_direction();
    t_polarity();
    t_level();
    t_mask_base();
    t_edge();
    t_falling();
    t_collision();
    t_group();
    t_blink();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule